// File: doc/BRIEF.md
# Two-Step Survivor Decision Combiner

This block sits on the write side of a Viterbi survivor memory. Each cycle the add-compare-select array hands it one decision bit per trellis state. The block pairs consecutive trellis steps. For every state it stores the best two-step path that ends in that state, as a 2-bit entry, rather than a single decision. A traceback reader then fetches one 2-bit entry and moves back two trellis steps in one lookup. It can use a narrow read port, so no wide multiplexer is needed after the memory.

The first decision vector of a pair is held in a per-state register. When the second vector arrives, a 2:1 multiplexer for each state uses that state's new decision to select the stored first-step bit of the predecessor. The predecessor of state `s` under decision `d` is `{d, s[K-1:1]}`, where K = log2(STATES). The resulting 256-bit pair word is written to the traceback memory as two 128-bit halves on consecutive cycles, both halves at the same pair address. The pair address steps once per completed pair and wraps modulo a parameterised depth, so the memory works as a circular buffer.

Top module: `two_step_combiner`

## Requirements
- R1: While reset is held and on the first cycle after it is released, `wrEn` is 0, `wrAddr` is 0 and `wrData` is all zeros.
- R2: In the pair word, bit 2s+1 of the entry for state s holds the decision that state s received on the second step of the pair.
- R3: Bit 2s of the entry for state s holds the first-step decision of the predecessor `{d2[s], s[6:1]}`, where d2[s] is state s's second-step decision.
- R4: On the cycle after the second valid decision vector of a pair is accepted, the block shows `wrEn`=1 and `wrHalf`=0, and `wrData` carries the entries of states 0 to 63 (state s at bits 2s+1:2s). On the next cycle it shows `wrEn`=1 and `wrHalf`=1 with the entries of states 64 to 127 (state 64+j at bits 2j+1:2j). `wrEn` is 0 on every other cycle.
- R5: `wrAddr` stays the same for both halves of a pair. It advances by exactly one on the cycle after the upper half is written, and at no other time.
- R6: After pair address DEPTH-1 (DEPTH = 16 by default), `wrAddr` returns to 0.
- R7: A cycle with `decValid` low is ignored. It does not advance the step phase, does not change the stored first-step decisions, and produces no write of its own.
- R8: Reset returns the step phase to the first step of a pair. A half-received pair is discarded, and the next valid vector after reset is taken as a first step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| decValid | input | 1 | Decision vector on `dec` is valid this cycle |
| dec | input | 128 | One ACS decision bit per state, bit s for state s |
| wrEn | output | 1 | Write strobe for the traceback memory |
| wrHalf | output | 1 | 0 selects the lower half (states 0 to 63), 1 selects the upper half (states 64 to 127) |
| wrAddr | output | 4 | Pair address in the circular traceback buffer |
| wrData | output | 128 | 64 two-bit entries of the selected half |

## Verification
The hardest case to reach is one where the predecessor chosen by R3 is checked for every state with both decision values. A single fixed pattern exercises only one branch of each state's multiplexer. The stimulus therefore streams many pairs of random 128-bit decision vectors, back to back and also with idle gaps between the two steps. Each half is compared with a trellis model in the bench that computes predecessors on its own. Wraparound of the pair address needs more than DEPTH consecutive pairs, so the random stream is long enough to pass address DEPTH-1. Reset in the middle of a pair is forced by asserting reset after only the first vector of a pair has been sent.

// File: rtl/combiner_pkg.sv
package combiner_pkg;

  // Strobes from the phase controller to the exchange datapath
  typedef struct packed {
    logic captureFirst;  // latch first-step decisions
    logic capturePair;   // form the two-step entries
    logic emitLo;        // present lower half of the pair word
    logic emitHi;        // present upper half of the pair word
  } strobe_t;

endpackage

// File: rtl/combiner_ctrl.sv
module combiner_ctrl
  import combiner_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              decValid,
  output strobe_t           strobes,
  output logic [ADDR_W-1:0] addr
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  logic phase;   // 0: first step of a pair, 1: second step
  logic emitLo;
  logic emitHi;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase  <= 1'b0;
      emitLo <= 1'b0;
      emitHi <= 1'b0;
      addr   <= '0;
    end else begin
      if (decValid) phase <= ~phase;
      emitLo <= decValid & phase;
      emitHi <= emitLo;
      if (emitHi) addr <= (addr == LAST_ADDR) ? '0 : addr + ADDR_W'(1);
    end
  end

  always_comb begin
    strobes.captureFirst = decValid & ~phase;
    strobes.capturePair  = decValid & phase;
    strobes.emitLo       = emitLo;
    strobes.emitHi       = emitHi;
  end

  // Halves are written on consecutive cycles and never together
  assert_hi_after_lo_R4: assert property (@(posedge clk) disable iff (!rstN)
    emitLo |=> emitHi);
  assert_halves_exclusive_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({emitLo, emitHi}));
  // Address moves only after the upper half
  assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!emitHi && !$past(!rstN)) |=> $stable(addr));
  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (emitHi && addr != LAST_ADDR) |=> addr == $past(addr) + ADDR_W'(1));
  assert_addr_wrap_R6: assert property (@(posedge clk) disable iff (!rstN)
    (emitHi && addr == LAST_ADDR) |=> addr == '0);
  // Idle cycles leave the step phase alone
  assert_idle_phase_R7: assert property (@(posedge clk) disable iff (!rstN)
    !decValid |=> $stable(phase));

endmodule

// File: rtl/combiner_dp.sv
module combiner_dp
  import combiner_pkg::*;
#(
  parameter int STATES = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [STATES-1:0] dec,
  output logic [STATES-1:0] wrData
);

  localparam int PAIR_W = 2 * STATES;
  localparam int HALF_S = STATES / 2;

  logic [STATES-1:0] firstReg;
  logic [PAIR_W-1:0] pairReg;
  logic [PAIR_W-1:0] pairNext;

  // Per-state exchange: pick the predecessor's first-step bit
  for (genvar s = 0; s < STATES; s++) begin : g_state
    localparam int PRED_LO = s / 2;
    localparam int PRED_HI = PRED_LO + HALF_S;
    logic oldBit;
    assign oldBit          = dec[s] ? firstReg[PRED_HI] : firstReg[PRED_LO];
    assign pairNext[2*s+1] = dec[s];
    assign pairNext[2*s]   = oldBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      firstReg <= '0;
      pairReg  <= '0;
    end else begin
      if (strobes.captureFirst) firstReg <= dec;
      if (strobes.capturePair)  pairReg  <= pairNext;
    end
  end

  assign wrData = strobes.emitHi ? pairReg[PAIR_W-1:STATES] : pairReg[STATES-1:0];

  // The first-step history changes only on a first-step capture
  assert_first_held_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.captureFirst && !$past(!rstN)) |=> $stable(firstReg));

endmodule

// File: rtl/two_step_combiner.sv
module two_step_combiner
  import combiner_pkg::*;
#(
  parameter int STATES = 128,
  parameter int DEPTH  = 16,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              decValid,
  input  logic [STATES-1:0] dec,
  output logic              wrEn,
  output logic              wrHalf,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [STATES-1:0] wrData
);

  strobe_t strobes;

  combiner_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .decValid (decValid),
    .strobes  (strobes),
    .addr     (wrAddr)
  );

  combiner_dp #(.STATES(STATES)) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .dec     (dec),
    .wrData  (wrData)
  );

  assign wrEn   = strobes.emitLo | strobes.emitHi;
  assign wrHalf = strobes.emitHi;

  // Lower half appears right after the second step, which carried state 0's newer bit
  assert_newer_bit_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrHalf) |-> (wrData[1] == $past(dec[0]) && $past(decValid)));
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(!rstN) |-> (!wrEn && wrAddr == '0));

endmodule

// File: tb/test_two_step_combiner.sv
`timescale 1ns/1ps
module test_two_step_combiner;

  localparam int STATES = 128;
  localparam int DEPTH  = 16;
  localparam int ADDR_W = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              decValid = 1'b0;
  logic [STATES-1:0] dec = '0;
  logic              wrEn;
  logic              wrHalf;
  logic [ADDR_W-1:0] wrAddr;
  logic [STATES-1:0] wrData;

  int checks = 0;
  int errors = 0;
  int expAddr = 0;
  logic havePrev = 1'b0;
  logic [2*STATES-1:0] prevWord;

  always #2.5 clk = ~clk;

  two_step_combiner i_two_step_combiner (
    .clk(clk), .rstN(rstN), .decValid(decValid), .dec(dec),
    .wrEn(wrEn), .wrHalf(wrHalf), .wrAddr(wrAddr), .wrData(wrData)
  );

  // Behavioural trellis model: entry s = {d2[s], d1[pred]}, pred = {d2[s], s[6:1]}
  function automatic logic [2*STATES-1:0] expPair(input logic [STATES-1:0] d1,
                                                   input logic [STATES-1:0] d2);
    logic [2*STATES-1:0] w;
    for (int s = 0; s < STATES; s++) begin
      int p;
      p = (d2[s] ? STATES/2 : 0) + s/2;
      w[2*s+1] = d2[s];
      w[2*s]   = d1[p];
    end
    return w;
  endfunction

  function automatic logic [STATES-1:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic checkOut(input logic en, input logic half, input logic [STATES-1:0] data,
                          input int addr, input string req);
    checks++;
    if (wrEn !== en || (en && (wrHalf !== half || wrData !== data)) || wrAddr !== ADDR_W'(addr)) begin
      errors++;
      $display("FAIL %s: got en=%0b half=%0b addr=%0d data=%h, expected en=%0b half=%0b addr=%0d data=%h",
               req, wrEn, wrHalf, wrAddr, wrData, en, half, addr, data);
    end
  endtask

  // Checks pending halves while the next pair streams in
  task automatic checkPrevHalf(input logic half, input string req);
    if (havePrev) begin
      checkOut(1'b1, half, half ? prevWord[2*STATES-1:STATES] : prevWord[STATES-1:0], expAddr, req);
      if (half) begin
        expAddr = (expAddr + 1) % DEPTH;
        havePrev = 1'b0;
      end
    end else begin
      checkOut(1'b0, 1'b0, '0, expAddr, req);
    end
  endtask

  task automatic sendPair(input logic [STATES-1:0] d1, input logic [STATES-1:0] d2,
                          input int gap, input string req);
    logic [2*STATES-1:0] w;
    w = expPair(d1, d2);
    decValid = 1'b1; dec = d1;
    checkPrevHalf(1'b0, req);
    step();
    for (int g = 0; g < gap; g++) begin
      decValid = 1'b0; dec = rnd128();   // ignored data (R7)
      checkPrevHalf(havePrev ? 1'b1 : 1'b0, {req, " R7"});
      step();
    end
    decValid = 1'b1; dec = d2;
    checkPrevHalf(1'b1, req);
    step();
    prevWord = w;
    havePrev = 1'b1;
  endtask

  task automatic drain(input string req);
    decValid = 1'b0; dec = '0;
    checkPrevHalf(1'b0, req);
    step();
    checkPrevHalf(1'b1, req);
    step();
    checkOut(1'b0, 1'b0, '0, expAddr, {req, " R5"});
  endtask

  task automatic doReset();
    rstN = 1'b0; decValid = 1'b0; dec = '0;
    step(); step();
    checkOut(1'b0, 1'b0, '0, 0, "R1 during reset");
    checks++;
    if (wrData !== '0) begin
      errors++;
      $display("FAIL R1: got data=%h, expected 0", wrData);
    end
    rstN = 1'b1;
    step();
    checkOut(1'b0, 1'b0, '0, 0, "R1 after release");
    expAddr = 0;
    havePrev = 1'b0;
  endtask

  task automatic testDirected();
    logic [STATES-1:0] d1, d2;
    // all-ones second step selects upper predecessors; alternating first step
    d1 = {64{2'b01}};
    d2 = '1;
    sendPair(d1, d2, 0, "R2 R3 R4 directed ones");
    d1 = {STATES{1'b1}} >> 64;
    d2 = '0;
    sendPair(d1, d2, 0, "R2 R3 R4 directed zeros");
    drain("R4 R5 directed");
  endtask

  task automatic testRandomStream();
    for (int k = 0; k < DEPTH + 5; k++)
      sendPair(rnd128(), rnd128(), 0, "R3 R5 R6 random stream");
    drain("R6 random stream");
  endtask

  task automatic testGaps();
    for (int k = 0; k < 6; k++)
      sendPair(rnd128(), rnd128(), 1 + (k % 3), "R7 gaps");
    drain("R7 gaps");
  endtask

  task automatic testMidPairReset();
    logic [STATES-1:0] d1, d2;
    decValid = 1'b1; dec = rnd128();    // lone first step, then reset
    step();
    doReset();
    d1 = rnd128(); d2 = rnd128();
    sendPair(d1, d2, 0, "R8 after mid-pair reset");
    drain("R8 after mid-pair reset");
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    doReset();
    testDirected();
    testRandomStream();
    testGaps();
    testMidPairReset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule